// File: doc/BRIEF.md
# AES-256 Key Schedule Generator

This block turns a 256-bit cipher key into the complete AES-256 key schedule. A one-cycle start request loads the eight key words into a 60-word schedule store. A small controller then walks a word counter from 8 to 60 and produces one new 32-bit schedule word on each clock. The new word is the word eight places back XORed with a transformed copy of the word just written. Depending on the word's position inside its group of eight, the transform is a byte rotation followed by S-box substitution and a round-constant XOR, S-box substitution alone, or no change.

The store is presented as fifteen 128-bit round keys. A ready flag marks the moment the whole schedule is valid. A fresh start request at any time clears the flag and begins again with the newly presented key. The S-box is computed from GF(2^8) arithmetic rather than held as a written-out table.

Top module: `aes_key_sched`

## Requirements
- R1: On the clock edge that samples start_i high, key_i is loaded as schedule words 0..7, word 0 being key_i[255:224]. Round key r occupies round_keys_o[128r+127:128r] and holds words 4r..4r+3, with word 4r in the top 32 bits. After loading, round key 0 equals key_i[255:128] and round key 1 equals key_i[127:0].
- R2: Words 8 through 59 are each built as w[i] = w[i-8] XOR T(w[i-1]), one word per clock, in increasing index order. The full schedule matches an independent AES-256 expansion.
- R3: When i mod 8 is 0, T rotates the word left by one byte, substitutes every byte through the AES S-box, and XORs the top byte with a round constant. That constant is 01, 02, 04, 08, 10, 20 or 40 (hex) for i/8 = 1..7, and the lower three bytes of the constant are zero.
- R4: When i mod 8 is 4, T substitutes every byte through the S-box with no rotation and no constant. For every other position T passes the word unchanged.
- R5: ready_o rises exactly 52 clock edges after the edge that samples start_i. It then stays high until the next start request or reset.
- R6: If start_i is high while ready_o is high, ready_o is low in the following cycle.
- R7: ready_o is low in every cycle that follows a cycle with start_i high. This holds when start_i is held for several cycles. A start during generation restarts the schedule from the new key.
- R8: Asynchronous active-low reset rst_ni clears ready_o and leaves the block idle. It stays idle with ready_o low until a start request arrives.
- R9: While start_i is low, changes on key_i have no effect on round_keys_o or ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to load key_i and build a new schedule |
| key_i | input | 256 | Cipher key, sampled only with start_i |
| ready_o | output | 1 | All fifteen round keys are valid |
| round_keys_o | output | 1920 | Fifteen 128-bit round keys, round r at bits [128r+127:128r] |

## Verification
The functions that can collide are the completion of a schedule and a new start request. A start can arrive in the very cycle a finished schedule sits under ready_o. It can also arrive in the middle of generation, while the counter is writing words. The bench provokes both. It pulses start while ready is high and expects ready low at the next sample. It restarts twenty cycles into a run with a different key. It then judges that ready returns exactly 52 cycles after the second request and that all fifteen round keys belong to the second key, not a mixture of the two.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int WORD_W      = 32;
  localparam int KEY_WORDS   = 8;
  localparam int N_ROUNDS    = 15;
  localparam int BLK_WORDS   = 4;
  localparam int BLK_W       = WORD_W * BLK_WORDS;
  localparam int KEY_W       = WORD_W * KEY_WORDS;
  localparam int TOTAL_WORDS = N_ROUNDS * BLK_WORDS;
  localparam int SCHED_W     = TOTAL_WORDS * WORD_W;
  localparam int CNT_W       = $clog2(TOTAL_WORDS + 1);
  localparam int PHASE_W     = $clog2(KEY_WORDS);
  localparam int RC_IDX_W    = 8;

  localparam logic [CNT_W-1:0]   CNT_FIRST = CNT_W'(KEY_WORDS);
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(TOTAL_WORDS - 1);
  localparam logic [CNT_W-1:0]   CNT_END   = CNT_W'(TOTAL_WORDS);
  localparam logic [PHASE_W-1:0] PH_ROT    = '0;
  localparam logic [PHASE_W-1:0] PH_SUB    = PHASE_W'(KEY_WORDS / 2);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GEN  = 3'd1,
    ST_DONE = 3'd2
  } ks_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = '0;
    logic [7:0] sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // inverse as x^254 by repeated squaring, then the affine map
  function automatic logic [7:0] sbox_byte(input logic [7:0] x);
    logic [7:0] p = x;
    logic [7:0] r = 8'h01;
    logic [7:0] s;
    for (int i = 0; i < 7; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    s = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
    return s;
  endfunction
endpackage

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import aes_ks_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o,
  output logic             rot_en_o,
  output logic             sub_en_o,
  output logic             rcon_en_o,
  output logic             xor_en_o
);
  ks_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= CNT_FIRST;
      ready_q <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_GEN;
      cnt_q   <= CNT_FIRST;
      ready_q <= 1'b0;
    end else if (state_q == ST_GEN) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        state_q <= ST_DONE;
        ready_q <= 1'b1;
      end
    end
  end

  assign phase     = cnt_q[PHASE_W-1:0];
  assign xor_en_o  = (state_q == ST_GEN) && !start_i;
  assign rot_en_o  = xor_en_o && (phase == PH_ROT);
  assign rcon_en_o = rot_en_o;
  assign sub_en_o  = xor_en_o && (phase == PH_ROT || phase == PH_SUB);
  assign cnt_o     = cnt_q;
  assign ready_o   = ready_q;

  assert_ready_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o);
  assert_ready_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);
  assert_ready_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (cnt_o == CNT_END) && $past(xor_en_o));
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o >= CNT_FIRST) && (cnt_o <= CNT_END));
  assert_rot_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_en_o |-> (sub_en_o && rcon_en_o && xor_en_o));
  assert_stage_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xor_en_o |-> !sub_en_o && !rot_en_o);
endmodule

// File: rtl/ks_parser.sv
module ks_parser
  import aes_ks_pkg::*;
(
  input  logic [WORD_W-1:0] words_i [TOTAL_WORDS],
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] last_w_o,
  output logic [WORD_W-1:0] back_w_o
);
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] back_idx;

  assign last_idx = cnt_i - 1'b1;
  assign back_idx = cnt_i - CNT_FIRST;

  always_comb begin
    last_w_o = '0;
    back_w_o = '0;
    if (en_i && cnt_i < CNT_END) begin
      last_w_o = words_i[last_idx];
      back_w_o = words_i[back_idx];
    end
  end
endmodule

// File: rtl/ks_sub_word.sv
module ks_sub_word
  import aes_ks_pkg::*;
(
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int N_BYTES = WORD_W / 8;
  logic [WORD_W-1:0] subst;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign subst[b*8 +: 8] = sbox_byte(word_i[b*8 +: 8]);
  end

  assign word_o = en_i ? subst : word_i;
endmodule

// File: rtl/ks_rcon.sv
module ks_rcon
  import aes_ks_pkg::*;
(
  input  logic                en_i,
  input  logic [RC_IDX_W-1:0] idx_i,
  output logic [WORD_W-1:0]   rcon_o
);
  logic [7:0] rc_byte;

  always_comb begin
    unique case (idx_i)
      8'd1:    rc_byte = 8'h01;
      8'd2:    rc_byte = 8'h02;
      8'd3:    rc_byte = 8'h04;
      8'd4:    rc_byte = 8'h08;
      8'd5:    rc_byte = 8'h10;
      8'd6:    rc_byte = 8'h20;
      8'd7:    rc_byte = 8'h40;
      default: rc_byte = 8'h00;
    endcase
  end

  assign rcon_o = en_i ? {rc_byte, {(WORD_W-8){1'b0}}} : '0;
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_ks_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic               ready_o,
  output logic [SCHED_W-1:0] round_keys_o
);
  logic [CNT_W-1:0]  cnt;
  logic              rot_en, sub_en, rcon_en, xor_en;
  logic [WORD_W-1:0] words_q [TOTAL_WORDS];
  logic [WORD_W-1:0] last_w, back_w, rot_w, sub_w, rcon_w, new_w;
  logic [RC_IDX_W-1:0] rc_idx;

  ks_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cnt_o     (cnt),
    .ready_o   (ready_o),
    .rot_en_o  (rot_en),
    .sub_en_o  (sub_en),
    .rcon_en_o (rcon_en),
    .xor_en_o  (xor_en)
  );

  ks_parser u_parser (
    .words_i  (words_q),
    .cnt_i    (cnt),
    .en_i     (xor_en),
    .last_w_o (last_w),
    .back_w_o (back_w)
  );

  assign rot_w = rot_en ? {last_w[WORD_W-9:0], last_w[WORD_W-1:WORD_W-8]} : last_w;

  ks_sub_word u_sub (
    .en_i   (sub_en),
    .word_i (rot_w),
    .word_o (sub_w)
  );

  assign rc_idx = RC_IDX_W'(cnt >> PHASE_W);

  ks_rcon u_rcon (
    .en_i   (rcon_en),
    .idx_i  (rc_idx),
    .rcon_o (rcon_w)
  );

  assign new_w = back_w ^ sub_w ^ rcon_w;

  for (genvar j = 0; j < TOTAL_WORDS; j++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_q[j] <= '0;
      end else if (start_i) begin
        if (j < KEY_WORDS) words_q[j] <= key_i[KEY_W-1-j*WORD_W -: WORD_W];
      end else if (xor_en && cnt == CNT_W'(j)) begin
        words_q[j] <= new_w;
      end
    end
    assign round_keys_o[(j/BLK_WORDS)*BLK_W + (BLK_WORDS-1-j%BLK_WORDS)*WORD_W +: WORD_W] = words_q[j];
  end

  assert_key_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> round_keys_o[BLK_W-1:0] == $past(key_i[KEY_W-1:BLK_W]));
  assert_key_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(round_keys_o));
endmodule

// File: tb/aes_key_sched_tb_top.sv
module aes_key_sched_tb_top;
  import aes_ks_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 52;
  localparam int N_KAT      = 4;
  localparam logic [KEY_W-1:0] KEY_SEQ =
    256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [KEY_W-1:0] KAT_KEY [N_KAT] = '{KEY_SEQ, KEY_SEQ, KEY_SEQ, KEY_SEQ};
  localparam int KAT_RND [N_KAT] = '{0, 1, 2, 14};
  localparam logic [BLK_W-1:0] KAT_EXP [N_KAT] = '{
    128'h000102030405060708090a0b0c0d0e0f,
    128'h101112131415161718191a1b1c1d1e1f,
    128'ha573c29fa176c498a97fce93a572c09c,
    128'h24fc79ccbf0979e9371ac23c6d68de36};
  localparam string KAT_REQ [N_KAT] = '{"R1", "R1", "R3", "R2"};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [KEY_W-1:0] key = '0;
  logic ready;
  logic [SCHED_W-1:0] rk;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_key_sched dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .key_i        (key),
    .ready_o      (ready),
    .round_keys_o (rk)
  );

  function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(logic [7:0] x);
    logic [7:0] inv = 0;
    logic [7:0] s;
    for (int y = 1; y < 256; y++)
      if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    s = 8'h63;
    for (int k = 0; k < 5; k++) s ^= (inv << k) | (inv >> (8 - k));
    return s;
  endfunction

  function automatic logic [SCHED_W-1:0] model(logic [KEY_W-1:0] k);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    logic [SCHED_W-1:0] out;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      t = w[i-1];
      if (i % 8 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
        t[31:24] ^= rc;
        rc = rc << 1;
      end else if (i % 8 == 4) begin
        t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
      end
      w[i] = w[i-8] ^ t;
    end
    for (int r = 0; r < 15; r++)
      out[r*128 +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return out;
  endfunction

  task automatic chk(string req, logic [BLK_W-1:0] act, logic [BLK_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [KEY_W-1:0] k);
    @(negedge clk);
    start = 1'b1;
    key   = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(logic [KEY_W-1:0] k);
    pulse(k);
    repeat (LATENCY) @(negedge clk);
  endtask

  task automatic chk_all(string req, logic [KEY_W-1:0] k);
    logic [SCHED_W-1:0] exp = model(k);
    for (int r = 0; r < N_ROUNDS; r++) chk(req, rk[r*BLK_W +: BLK_W], exp[r*BLK_W +: BLK_W]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [KEY_W-1:0] ka, kb;
    repeat (3) @(negedge clk);
    chk("R8", {127'b0, ready}, '0);
    rst_ni = 1'b1;

    // known-answer table
    for (int v = 0; v < N_KAT; v++) begin
      run(KAT_KEY[v]);
      chk(KAT_REQ[v], rk[KAT_RND[v]*BLK_W +: BLK_W], KAT_EXP[v]);
    end

    // R5: exact ready latency
    ka = {8{32'hdeadbeef}} ^ KEY_SEQ;
    pulse(ka);
    repeat (LATENCY - 1) @(negedge clk);
    chk("R5", {127'b0, ready}, '0);
    @(negedge clk);
    chk("R5", {127'b0, ready}, 128'd1);
    chk_all("R4", ka);

    // R9: key change without start is ignored
    key = ~ka;
    repeat (5) @(negedge clk);
    chk("R9", {127'b0, ready}, 128'd1);
    chk_all("R9", ka);

    // R6: start while ready drops it next cycle
    pulse(KEY_SEQ);
    chk("R6", {127'b0, ready}, '0);
    repeat (LATENCY) @(negedge clk);

    // R7: held start keeps ready low
    @(negedge clk);
    start = 1'b1;
    key = ka;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R7", {127'b0, ready}, '0);
    end
    start = 1'b0;
    repeat (LATENCY) @(negedge clk);
    chk("R7", {127'b0, ready}, 128'd1);
    chk_all("R7", ka);

    // R7: restart mid-generation
    kb = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    pulse(KEY_SEQ);
    repeat (20) @(negedge clk);
    pulse(kb);
    repeat (LATENCY - 1) @(negedge clk);
    chk("R7", {127'b0, ready}, '0);
    @(negedge clk);
    chk("R7", {127'b0, ready}, 128'd1);
    chk_all("R7", kb);

    // R2: random keys against the model
    for (int n = 0; n < 3; n++) begin
      ka = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      run(ka);
      chk_all("R2", ka);
    end

    // R8: reset during generation
    pulse(kb);
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R8", {127'b0, ready}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (LATENCY + 8) @(negedge clk);
    chk("R8", {127'b0, ready}, '0);

    finish_run();
  end
endmodule